// File: doc/BRIEF.md
# Horizontal line interrupt counter

This block produces a raster line interrupt once every N+1 visible lines, where N is a programmable reload value. A timing generator supplies a one-cycle strobe at the point in each line where the line number advances, and a level that is high while the current line lies in the blanking (non-visible) part of the frame. The counter acts only on that strobe. On every blanking line it is reloaded, so the interrupt cadence starts again at the top of each frame.

On a visible line the counter steps down by one. If it has already reached zero, it sets a sticky pending flag and reloads itself in the same evaluation. The pending flag stays set until software acknowledges it. The request sent to the processor is the pending flag gated by an enable bit. A side output gives how many more visible-line evaluations will pass before the next one that fires. It shows all ones when the enable is off, meaning no line interrupt is expected.

Top module: `hline_irq_top`

## Requirements
- R1: After reset the pending flag and the interrupt request are low, and the internal count is zero, so with the enable high the query output reads 0.
- R2: The count changes only in cycles where `line_stb_i` is high. Cycles without a strobe leave it unchanged, whatever the other inputs do.
- R3: A strobe with `inactive_i` high loads the count with `reload_i` and does not set the pending flag.
- R4: A strobe with `inactive_i` low and a nonzero count lowers the count by exactly one and does not set the pending flag.
- R5: A strobe with `inactive_i` low and a zero count sets the pending flag and loads the count with `reload_i`. Both changes are visible in the cycle after the strobe.
- R6: Once set, the pending flag stays high until a cycle with `ack_i` high. In that case it is low from the next cycle, unless R7 applies.
- R7: If `ack_i` is high in the same cycle as an event that sets the flag, the flag is high after that cycle.
- R8: `irq_o` equals the pending flag ANDed with `irq_en_i`. The pending flag is set whatever `irq_en_i` is, so raising the enable later makes a request that was held back visible.
- R9: `next_o` is 9 bits wide. It is all ones (0x1FF) while `irq_en_i` is low. Otherwise it holds the current count zero-extended, which is the number of visible-line strobes still to pass before the one that fires.
- R10: With `reload_i` equal to 0, every strobe on a visible line sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_stb_i | input | 1 | One-cycle pulse at the line-change point |
| inactive_i | input | 1 | High while the current line is in the blanking region |
| reload_i | input | 8 | Reload value N (interrupt every N+1 visible lines) |
| irq_en_i | input | 1 | Line interrupt enable |
| ack_i | input | 1 | Clears the pending flag |
| pend_o | output | 1 | Sticky line interrupt pending flag |
| irq_o | output | 1 | Gated interrupt request |
| next_o | output | 9 | Visible-line evaluations left before the next firing, all ones when disabled |

## Verification
A wrong count has no effect on `pend_o` or `irq_o` until the next firing, which may be many lines away. Because `next_o` exposes the count, any mistake in a load, a step or a hold appears at the ports in the very cycle after the strobe that caused it. A pending flag that is lost or sticks shows at `pend_o` one cycle after the acknowledge or set. The bench compares all three outputs against a behavioural model on every clock, so a divergence is reported within one cycle of its cause.

// File: rtl/hline_pkg.sv
`timescale 1ns/1ps
package hline_pkg;
  // What a single evaluation does to the counter.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,  // no strobe this cycle
    EV_LOAD = 2'd1,  // blanking line: reload
    EV_STEP = 2'd2,  // visible line, count nonzero: decrement
    EV_FIRE = 2'd3   // visible line, count zero: raise pending and reload
  } hl_event_e;
endpackage

// File: rtl/hline_rst_sync.sv
`timescale 1ns/1ps
module hline_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/hline_decide.sv
`timescale 1ns/1ps
module hline_decide
  import hline_pkg::*;
(
  input  logic      stb_i,
  input  logic      inactive_i,
  input  logic      cnt_zero_i,
  output hl_event_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (stb_i) begin
      if (inactive_i)      ev_o = EV_LOAD;
      else if (cnt_zero_i) ev_o = EV_FIRE;
      else                 ev_o = EV_STEP;
    end
  end
endmodule

// File: rtl/hline_count.sv
`timescale 1ns/1ps
module hline_count
  import hline_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hl_event_e     ev_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (ev_i != EV_NONE);
    unique case (ev_i)
      EV_STEP: cnt_d = cnt_q - CW'(1);
      EV_LOAD,
      EV_FIRE: cnt_d = reload_i;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R2
  hold_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_NONE) |=> $stable(cnt_q));
  // R3
  load_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_LOAD) |=> (cnt_q == $past(reload_i)));
  // R4
  step_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_STEP) |-> (cnt_q != '0));
  // R5
  fire_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_FIRE) |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/hline_pend.sv
`timescale 1ns/1ps
module hline_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (ack_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R5 and R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q);
  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> pend_q);
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !pend_q);
endmodule

// File: rtl/hline_irq_top.sv
`timescale 1ns/1ps
module hline_irq_top
  import hline_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_stb_i,
  input  logic          inactive_i,
  input  logic [RW-1:0] reload_i,
  input  logic          irq_en_i,
  input  logic          ack_i,
  output logic          pend_o,
  output logic          irq_o,
  output logic [RW:0]   next_o
);
  localparam int QW = RW + 1;

  logic          rst_s;
  hl_event_e     ev;
  logic [RW-1:0] cnt;
  logic          cnt_zero;
  logic          fire;

  hline_rst_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  hline_decide u_decide (
    .stb_i      (line_stb_i),
    .inactive_i (inactive_i),
    .cnt_zero_i (cnt_zero),
    .ev_o       (ev)
  );

  hline_count #(.CW(RW)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_s),
    .ev_i     (ev),
    .reload_i (reload_i),
    .cnt_o    (cnt),
    .zero_o   (cnt_zero)
  );

  assign fire = (ev == EV_FIRE);

  hline_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .set_i  (fire),
    .ack_i  (ack_i),
    .pend_o (pend_o)
  );

  assign irq_o  = pend_o & irq_en_i;
  assign next_o = irq_en_i ? {1'b0, cnt} : {QW{1'b1}};

  // R5 and R10: the flag only rises after a visible-line strobe
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    $rose(pend_o) |-> $past(line_stb_i && !inactive_i));
  // R3: blanking strobes never raise the flag
  blank_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (line_stb_i && inactive_i && !pend_o) |=> !pend_o);
endmodule

// File: tb/hline_irq_top_test.sv
`timescale 1ns/1ps
module hline_irq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic       inact = 1'b0;
  logic [7:0] reload = 8'd0;
  logic       en = 1'b1;
  logic       ack = 1'b0;
  logic       pend_o;
  logic       irq_o;
  logic [8:0] next_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference
  int m_cnt = 0;
  bit m_pend = 1'b0;

  always #4 clk = ~clk;

  hline_irq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .line_stb_i(stb), .inactive_i(inact),
    .reload_i(reload), .irq_en_i(en), .ack_i(ack),
    .pend_o(pend_o), .irq_o(irq_o), .next_o(next_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_pend = 1'b0;
    end else begin
      bit fire;
      fire = 1'b0;
      if (stb) begin
        if (inact) m_cnt = reload;
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        else begin
          fire  = 1'b1;
          m_cnt = reload;
        end
      end
      if (ack) m_pend = 1'b0;
      if (fire) m_pend = 1'b1;
    end
  end

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check1(tag, "pend_o", pend_o, m_pend);
    check1(tag, "irq_o", irq_o, m_pend & en);
    check1(tag, "next_o", next_o, en ? m_cnt : 511);
  endtask

  // compare at the falling edge, then drive the next inputs
  task automatic step(input string tag, input bit s, input bit i, input int r,
                      input bit e, input bit a);
    @(negedge clk);
    compare(tag);
    stb = s; inact = i; reload = 8'(r); en = e; ack = a;
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag, 1'b0, inact, reload, en, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check1("R1", "pend_o", pend_o, 0);
    check1("R1", "irq_o", irq_o, 0);
    check1("R1", "next_o", next_o, 0);
    // R2: no strobe, inputs wiggle, count holds
    step("R2", 0, 1, 77, 1, 0);
    step("R2", 0, 0, 12, 1, 1);
    idle("R2", 3);
    // R3: blanking strobe loads
    step("R3", 1, 1, 3, 1, 0);
    step("R3", 0, 1, 3, 1, 0);
    check1("R3", "next_o load", next_o, 3);
    // R4: visible strobes decrement, spaced apart
    for (int k = 0; k < 3; k++) begin
      step("R4", 1, 0, 3, 1, 0);
      step("R4", 0, 0, 3, 1, 0);
      check1("R4", "next_o step", next_o, 2 - k);
      check1("R4", "pend_o quiet", pend_o, 0);
    end
    // R5: count zero fires and reloads
    step("R5", 1, 0, 5, 1, 0);
    step("R5", 0, 0, 5, 1, 0);
    check1("R5", "pend_o fire", pend_o, 1);
    check1("R5", "next_o reload", next_o, 5);
    // R6: sticky then acknowledge
    idle("R6", 4);
    check1("R6", "pend_o hold", pend_o, 1);
    step("R6", 0, 0, 5, 1, 1);
    step("R6", 0, 0, 5, 1, 0);
    check1("R6", "pend_o ack", pend_o, 0);
    // R8, R9: disabled fire still pends, query all ones
    step("R8", 1, 1, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0);
    check1("R8", "pend_o disabled", pend_o, 1);
    check1("R8", "irq_o disabled", irq_o, 0);
    check1("R9", "next_o disabled", next_o, 511);
    step("R8", 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 1, 0);
    check1("R8", "irq_o enabled", irq_o, 1);
    // R7: ack together with a fire
    step("R7", 1, 0, 0, 1, 1);
    step("R7", 0, 0, 0, 1, 0);
    check1("R7", "pend_o ack+set", pend_o, 1);
    // R10: reload 0 fires every visible line
    for (int k = 0; k < 4; k++) begin
      step("R10", 0, 0, 0, 1, 1);
      step("R10", 1, 0, 0, 1, 0);
      step("R10", 0, 0, 0, 1, 0);
      check1("R10", "pend_o each line", pend_o, 1);
    end
    // R2..R5: frames with random gaps, reload and acks
    for (int f = 0; f < 20; f++) begin
      int rl;
      rl = $urandom_range(0, 6);
      for (int ln = 0; ln < 30; ln++) begin
        bit bl;
        bl = (ln >= 24);
        step("R2", 1, bl, rl, ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) == 0));
        for (int g = 0; g < int'($urandom_range(0, 3)); g++)
          step("R4", 0, bl, rl, en, ($urandom_range(0, 5) == 0));
      end
    end
    idle("R2", 2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule